// File: doc/BRIEF.md
# Compare flags and branch condition unit

This block performs a compare: it subtracts a second operand from a first one at either byte or word width and discards the difference. From that subtraction it produces the six arithmetic status flags: carry/borrow, zero, sign, overflow, parity and half-borrow. It also packs the flags into a fixed byte image. From the same flags it then decides whether a conditional branch is taken. A 5-bit condition select chooses that branch test from a set of unsigned, signed and single-flag tests, plus a test for a zero count.

A separate loop-kind select turns the unit into a loop evaluator. In that mode it decrements the count it is given and returns the new count. The take bit then depends on the new count, and, for two of the loop kinds, on the zero flag of the compare done in the same cycle. All results go through one register stage. The results for the inputs applied before a rising clock edge appear on the outputs after that edge. Target address computation and instruction fetch belong to the surrounding pipeline.

Top module: `cmp_branch_unit`

## Requirements
- R1: With `wide`=1 the compare is 16 bits wide. With `wide`=0 only bits 7:0 of each operand take part and bits 15:8 have no effect. `flag_cf` is the borrow out of the top bit at the selected width.
- R2: `flag_zf` is 1 exactly when the difference at the selected width is zero. `flag_sf` is the top bit of that difference (bit 15 when wide, bit 7 when narrow).
- R3: `flag_of` is 1 when the operands' sign bits differ and the sign of the difference differs from the first operand's sign. At byte width, 0xFB compared with 0x7F gives 1, and 0xFB compared with 0x02 gives 0.
- R4: `flag_pf` is 1 when bits 7:0 of the difference hold an even number of ones, at both widths. `flag_af` is the borrow out of bit 3.
- R5: `flag_byte` bits 7 down to 0 are SF, ZF, 0, AF, 0, PF, 1, CF.
- R6: Unsigned tests. Code 7 (above) takes when CF=0 and ZF=0. Code 3 (above or equal) takes when CF=0. Code 2 (below) takes when CF=1. Code 6 (below or equal) takes when CF=1 or ZF=1.
- R7: Signed tests. Code 15 (greater) takes when ZF=0 and SF=OF. Code 13 (greater or equal) takes when SF=OF. Code 12 (less) takes when SF≠OF. Code 14 (less or equal) takes when SF≠OF or ZF=1.
- R8: Single-flag tests. Code 0 takes on OF=1 and code 1 on OF=0. Code 4 takes on ZF=1 and code 5 on ZF=0. Code 8 takes on SF=1 and code 9 on SF=0. Code 10 takes on PF=1 and code 11 on PF=0. Code 16 takes when `count_in` is 0. CF=1 and CF=0 are tested by codes 2 and 3.
- R9: Codes 17 to 31 never take when `loop_sel`=0.
- R10: With `loop_sel`=0, `count_out` equals `count_in` and the condition code decides `take`. With `loop_sel`≠0, `count_out` is `count_in`−1 (modulo 2^16) and the condition code is ignored. `take` then requires the new count to be non-zero, and additionally ZF=1 for `loop_sel`=2 or ZF=0 for `loop_sel`=3; `loop_sel`=1 needs only the non-zero count.
- R11: Every output shows the result of the inputs sampled at the previous rising edge. While `rst_n` is low, all flags, `take` and `count_out` are 0 and `flag_byte` is 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| op_a | input | 16 | First compare operand (minuend) |
| op_b | input | 16 | Second compare operand (subtrahend) |
| wide | input | 1 | 1: word compare, 0: byte compare |
| cond_sel | input | 5 | Branch condition code |
| loop_sel | input | 2 | 0: plain branch, 1: loop, 2: loop while equal, 3: loop while not equal |
| count_in | input | 16 | Count register value |
| flag_cf | output | 1 | Borrow flag |
| flag_zf | output | 1 | Zero flag |
| flag_sf | output | 1 | Sign flag |
| flag_of | output | 1 | Overflow flag |
| flag_pf | output | 1 | Parity flag |
| flag_af | output | 1 | Half-borrow flag |
| flag_byte | output | 8 | Packed flag image |
| take | output | 1 | Branch or loop taken |
| count_out | output | 16 | Count after this instruction |

## Verification
The assertions assume that every input is a defined 0/1 value at each rising edge once reset is released. They also assume that the operands above bit 7 may carry any value in byte mode, since the checks on the registered outputs compare against inputs held over exactly one edge. The stimulus changes inputs only on falling edges, holds them steady through the following rising edge, and drives all-zero values during reset. Random operands are drawn from the full 16-bit range in both widths, so the upper operand bytes are exercised while byte mode must ignore them.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  // Condition codes; values 17..31 are left unassigned on purpose.
  typedef enum logic [4:0] {
    C_OVF     = 5'd0,
    C_NOVF    = 5'd1,
    C_BELOW   = 5'd2,
    C_AE      = 5'd3,
    C_EQ      = 5'd4,
    C_NE      = 5'd5,
    C_BE      = 5'd6,
    C_ABOVE   = 5'd7,
    C_NEG     = 5'd8,
    C_POS     = 5'd9,
    C_PEVEN   = 5'd10,
    C_PODD    = 5'd11,
    C_LESS    = 5'd12,
    C_GE      = 5'd13,
    C_LE      = 5'd14,
    C_GREATER = 5'd15,
    C_CNTZ    = 5'd16
  } cond_e;

  typedef enum logic [1:0] {
    LK_NONE     = 2'd0,
    LK_PLAIN    = 2'd1,
    LK_WHILE_EQ = 2'd2,
    LK_WHILE_NE = 2'd3
  } loop_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
    logic pf;
    logic af;
  } flags_t;

  // Even number of ones in a byte gives 1.
  function automatic logic even_ones8(input logic [7:0] v);
    return ~^v;
  endfunction

  // Signed overflow of a - b from the three sign bits.
  function automatic logic sub_overflow(input logic sa, input logic sb, input logic sr);
    return (sa != sb) && (sr != sa);
  endfunction

  // Fixed flag byte image: SF ZF 0 AF 0 PF 1 CF (bit 7 down to 0).
  function automatic logic [7:0] pack_flags(input flags_t f);
    return {f.sf, f.zf, 1'b0, f.af, 1'b0, f.pf, 1'b1, f.cf};
  endfunction

endpackage

// File: rtl/cbu_sub.sv
module cbu_sub
  import cbu_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          wide,
  output flags_t        flags,
  output logic          sign_a,
  output logic          sign_b,
  output logic          sign_r
);
  localparam int unsigned HW = DW / 2;

  logic [DW:0]   full_diff;
  logic [HW:0]   half_diff;
  logic [4:0]    nib_diff;
  logic [DW-1:0] res;
  logic          borrow_out;

  always_comb begin
    full_diff = {1'b0, a} - {1'b0, b};
    half_diff = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]};
    nib_diff  = {1'b0, a[3:0]} - {1'b0, b[3:0]};
    if (wide) begin
      res        = full_diff[DW-1:0];
      borrow_out = full_diff[DW];
      sign_a     = a[DW-1];
      sign_b     = b[DW-1];
      sign_r     = full_diff[DW-1];
    end else begin
      res        = {{(DW-HW){1'b0}}, half_diff[HW-1:0]};
      borrow_out = half_diff[HW];
      sign_a     = a[HW-1];
      sign_b     = b[HW-1];
      sign_r     = half_diff[HW-1];
    end
  end

  always_comb begin
    flags.cf = borrow_out;
    flags.zf = (res == '0);
    flags.sf = sign_r;
    flags.of = sub_overflow(sign_a, sign_b, sign_r);
    flags.pf = even_ones8(res[7:0]);
    flags.af = nib_diff[4];
  end

endmodule

// File: rtl/cbu_cond.sv
module cbu_cond
  import cbu_pkg::*;
(
  input  flags_t     flags,
  input  logic [4:0] cond,
  input  logic       cnt_zero,
  output logic       cond_take
);
  logic signed_lt;
  logic unsigned_le;

  assign signed_lt   = flags.sf ^ flags.of;
  assign unsigned_le = flags.cf | flags.zf;

  always_comb begin
    case (cond)
      C_OVF:     cond_take = flags.of;
      C_NOVF:    cond_take = !flags.of;
      C_BELOW:   cond_take = flags.cf;
      C_AE:      cond_take = !flags.cf;
      C_EQ:      cond_take = flags.zf;
      C_NE:      cond_take = !flags.zf;
      C_BE:      cond_take = unsigned_le;
      C_ABOVE:   cond_take = !unsigned_le;
      C_NEG:     cond_take = flags.sf;
      C_POS:     cond_take = !flags.sf;
      C_PEVEN:   cond_take = flags.pf;
      C_PODD:    cond_take = !flags.pf;
      C_LESS:    cond_take = signed_lt;
      C_GE:      cond_take = !signed_lt;
      C_LE:      cond_take = signed_lt | flags.zf;
      C_GREATER: cond_take = !signed_lt & !flags.zf;
      C_CNTZ:    cond_take = cnt_zero;
      default:   cond_take = 1'b0;
    endcase
  end

endmodule

// File: rtl/cbu_loop.sv
module cbu_loop
  import cbu_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic [CW-1:0] count_in,
  input  logic [1:0]    kind,
  input  logic          zf,
  input  logic          cond_take,
  output logic          cnt_zero,
  output logic          take,
  output logic [CW-1:0] count_out
);
  logic [CW-1:0] dec_count;
  logic          dec_nonzero;
  logic          zf_ok;

  assign cnt_zero    = (count_in == '0);
  assign dec_count   = count_in - CW'(1);
  assign dec_nonzero = (dec_count != '0);

  always_comb begin
    case (kind)
      LK_WHILE_EQ: zf_ok = zf;
      LK_WHILE_NE: zf_ok = !zf;
      default:     zf_ok = 1'b1;
    endcase
    if (kind == LK_NONE) begin
      take      = cond_take;
      count_out = count_in;
    end else begin
      take      = dec_nonzero & zf_ok;
      count_out = dec_count;
    end
  end

endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cbu_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          wide,
  input  logic [4:0]    cond_sel,
  input  logic [1:0]    loop_sel,
  input  logic [CW-1:0] count_in,
  output logic          flag_cf,
  output logic          flag_zf,
  output logic          flag_sf,
  output logic          flag_of,
  output logic          flag_pf,
  output logic          flag_af,
  output logic [7:0]    flag_byte,
  output logic          take,
  output logic [CW-1:0] count_out
);
  flags_t        flags_w, flags_q;
  logic          sign_a_w, sign_b_w, sign_r_w;
  logic          cond_take_w, cnt_zero_w, take_w;
  logic [CW-1:0] count_w;
  logic [4:0]    cond_q;
  logic [1:0]    loop_q;
  logic          past_ok;

  cbu_sub #(.DW(DW)) u_sub (
    .a(op_a), .b(op_b), .wide(wide), .flags(flags_w),
    .sign_a(sign_a_w), .sign_b(sign_b_w), .sign_r(sign_r_w)
  );

  cbu_cond u_cond (
    .flags(flags_w), .cond(cond_sel), .cnt_zero(cnt_zero_w), .cond_take(cond_take_w)
  );

  cbu_loop #(.CW(CW)) u_loop (
    .count_in(count_in), .kind(loop_sel), .zf(flags_w.zf), .cond_take(cond_take_w),
    .cnt_zero(cnt_zero_w), .take(take_w), .count_out(count_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q   <= '0;
      take      <= 1'b0;
      count_out <= '0;
      cond_q    <= '0;
      loop_q    <= '0;
      past_ok   <= 1'b0;
    end else begin
      flags_q   <= flags_w;
      take      <= take_w;
      count_out <= count_w;
      cond_q    <= cond_sel;
      loop_q    <= loop_sel;
      past_ok   <= 1'b1;
    end
  end

  assign flag_cf   = flags_q.cf;
  assign flag_zf   = flags_q.zf;
  assign flag_sf   = flags_q.sf;
  assign flag_of   = flags_q.of;
  assign flag_pf   = flags_q.pf;
  assign flag_af   = flags_q.af;
  assign flag_byte = pack_flags(flags_q);

  // R3: operands of equal sign can never overflow on subtraction
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (sign_a_w == sign_b_w) |-> !flags_w.of);

  // R2: zero flag means the operands match at the selected width
  a_r2_zero_equal: assert property (@(posedge clk) disable iff (!rst_n)
    flags_w.zf |-> (wide ? (op_a == op_b) : (op_a[7:0] == op_b[7:0])));

  // R6: a taken unsigned-above branch saw neither borrow nor zero
  a_r6_above: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (loop_q == LK_NONE && cond_q == C_ABOVE && take) |-> (!flag_cf && !flag_zf));

  // R7: a taken signed-less branch saw sign differ from overflow
  a_r7_less: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (loop_q == LK_NONE && cond_q == C_LESS && take) |-> (flag_sf != flag_of));

  // R9: unassigned codes never take
  a_r9_unassigned: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (loop_q == LK_NONE && cond_q > 5'd16) |-> !take);

  // R10: loop forms return the decremented count
  a_r10_loop_count: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (loop_q != LK_NONE) |-> (count_out == ($past(count_in) - CW'(1))));

endmodule

// File: tb/tb_cmp_branch_unit.sv
`timescale 1ns/1ps
module tb_cmp_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] op_a, op_b, count_in;
  logic        wide;
  logic [4:0]  cond_sel;
  logic [1:0]  loop_sel;
  logic        flag_cf, flag_zf, flag_sf, flag_of, flag_pf, flag_af, take;
  logic [7:0]  flag_byte;
  logic [15:0] count_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  cmp_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .wide(wide),
    .cond_sel(cond_sel), .loop_sel(loop_sel), .count_in(count_in),
    .flag_cf(flag_cf), .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of),
    .flag_pf(flag_pf), .flag_af(flag_af), .flag_byte(flag_byte),
    .take(take), .count_out(count_out)
  );

  function automatic logic [30:0] actual_vec();
    return {flag_cf, flag_zf, flag_sf, flag_of, flag_pf, flag_af, flag_byte, take, count_out};
  endfunction

  // Behavioural reference built from integer arithmetic and comparisons.
  function automatic logic [30:0] model(input logic [15:0] a, input logic [15:0] b,
                                        input logic w, input int c, input int lk,
                                        input logic [15:0] cnt);
    int bits = w ? 16 : 8;
    int mask = (1 << bits) - 1;
    int ua = int'(a) & mask;
    int ub = int'(b) & mask;
    int sa = (ua >= (1 << (bits - 1))) ? ua - (1 << bits) : ua;
    int sb = (ub >= (1 << (bits - 1))) ? ub - (1 << bits) : ub;
    int d = ua - ub;
    int sd = sa - sb;
    int res = d & mask;
    int ones = 0;
    int ncnt;
    logic cf, zf, sf, of, pf, af, tk;
    logic [15:0] ec;
    cf = (d < 0);
    zf = (res == 0);
    sf = ((res >> (bits - 1)) & 1) != 0;
    of = (sd > (1 << (bits - 1)) - 1) || (sd < -(1 << (bits - 1)));
    af = (ua % 16) < (ub % 16);
    for (int i = 0; i < 8; i++) ones += (res >> i) & 1;
    pf = (ones % 2) == 0;
    case (c)
      0: tk = of;        1: tk = !of;
      2: tk = ua < ub;   3: tk = ua >= ub;
      4: tk = ua == ub;  5: tk = ua != ub;
      6: tk = ua <= ub;  7: tk = ua > ub;
      8: tk = sf;        9: tk = !sf;
      10: tk = pf;       11: tk = !pf;
      12: tk = sa < sb;  13: tk = sa >= sb;
      14: tk = sa <= sb; 15: tk = sa > sb;
      16: tk = (cnt == 16'd0);
      default: tk = 1'b0;
    endcase
    if (lk == 0) begin
      ec = cnt;
    end else begin
      ncnt = (int'(cnt) + 65535) % 65536;
      ec = ncnt[15:0];
      tk = (ncnt != 0) && ((lk == 1) || (lk == 2 && ua == ub) || (lk == 3 && ua != ub));
    end
    return {cf, zf, sf, of, pf, af, {sf, zf, 1'b0, af, 1'b0, pf, 1'b1, cf}, tk, ec};
  endfunction

  task automatic check(input logic [30:0] exp, input string tag);
    logic [30:0] act = actual_vec();
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, compare at the next falling edge (one register stage).
  task automatic step(input logic [15:0] a, input logic [15:0] b, input logic w,
                      input int c, input int lk, input logic [15:0] cnt, input string tag);
    logic [30:0] exp;
    op_a = a; op_b = b; wide = w; cond_sel = c[4:0]; loop_sel = lk[1:0]; count_in = cnt;
    exp = model(a, b, w, c, lk, cnt);
    @(negedge clk);
    check(exp, tag);
  endtask

  initial begin
    rst_n = 1'b0;
    op_a = '0; op_b = '0; wide = 1'b0; cond_sel = '0; loop_sel = '0; count_in = '0;
    repeat (3) @(negedge clk);
    check({6'b0, 8'h02, 1'b0, 16'h0000}, "R11 reset state");
    rst_n = 1'b1;

    step(16'h00FB, 16'h007F, 0, 0, 0, 0, "R3 -5 vs 127 overflow");
    step(16'h00FB, 16'h0002, 0, 0, 0, 0, "R3 -5 vs 2 no overflow");
    step(16'hAB05, 16'h1203, 0, 2, 0, 0, "R1 narrow ignores upper bytes");
    step(16'h0001, 16'h0002, 1, 2, 0, 0, "R1 wide borrow");
    step(16'h0100, 16'h0001, 0, 4, 0, 0, "R1 narrow zero with upper bits set");
    step(16'h1234, 16'h1234, 1, 4, 0, 0, "R2 equal operands");
    step(16'h8000, 16'h0000, 1, 8, 0, 0, "R2 wide sign");
    step(16'h0010, 16'h0001, 1, 10, 0, 0, "R4 parity and half borrow");
    step(16'h0300, 16'h0001, 1, 11, 0, 0, "R4 parity from low byte only");
    step(16'h0080, 16'h0000, 0, 9, 0, 0, "R5 flag byte image");
    step(16'h00FA, 16'h0005, 0, 7, 0, 0, "R6 above");
    step(16'h0005, 16'h0005, 0, 7, 0, 0, "R6 above on equal");
    step(16'h0005, 16'h0005, 0, 3, 0, 0, "R6 above or equal");
    step(16'h0005, 16'h0005, 0, 6, 0, 0, "R6 below or equal");
    step(16'h0005, 16'h00FB, 0, 15, 0, 0, "R7 greater signed");
    step(16'h0005, 16'h00FB, 0, 12, 0, 0, "R7 less signed");
    step(16'hFFFE, 16'h0005, 1, 14, 0, 0, "R7 less or equal wide");
    step(16'h0002, 16'h00FD, 0, 13, 0, 0, "R7 greater or equal");
    step(16'h0000, 16'h0000, 1, 16, 0, 0, "R8 count zero");
    step(16'h0000, 16'h0000, 1, 16, 0, 5, "R8 count nonzero");
    step(16'h0007, 16'h0000, 0, 1, 0, 0, "R8 no overflow code");
    step(16'h0001, 16'h0009, 1, 20, 0, 0, "R9 code 20");
    step(16'h0000, 16'h0000, 1, 31, 0, 0, "R9 code 31");
    step(16'h0000, 16'h0001, 0, 17, 0, 0, "R9 code 17");
    step(16'h0000, 16'h0000, 1, 4, 1, 1, "R10 loop ends at one");
    step(16'h0000, 16'h0000, 1, 4, 1, 5, "R10 loop continues");
    step(16'h0000, 16'h0001, 1, 4, 1, 0, "R10 loop wraps from zero");
    step(16'h0042, 16'h0042, 0, 31, 2, 3, "R10 while equal with equal");
    step(16'h0042, 16'h0043, 0, 31, 2, 3, "R10 while equal with unequal");
    step(16'h0042, 16'h0042, 0, 31, 3, 3, "R10 while not equal with equal");
    step(16'h0042, 16'h0043, 0, 31, 3, 3, "R10 while not equal with unequal");
    step(16'h0042, 16'h0042, 0, 31, 0, 16'hBEEF, "R10 count passes through");

    for (int n = 0; n < 3000; n++) begin
      int sel = $urandom_range(0, 9);
      logic [15:0] ra = 16'($urandom());
      logic [15:0] rb = (sel == 0) ? ra : 16'($urandom());
      logic [15:0] rc = (sel == 1) ? 16'($urandom_range(0, 2)) : 16'($urandom());
      step(ra, rb, 1'($urandom()), $urandom_range(0, 31),
           (sel < 4) ? $urandom_range(1, 3) : 0, rc, "R6 R7 R8 R10 R11 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule